// File: doc/BRIEF.md
# TDM Serial Voice-Port Channel Interface

This block sits between a voice codec core and an external serial link and moves 8-bit channel bytes in both directions. It runs from the link's own clock and works in one of two modes chosen by a pin. In framed TDM mode a one-cycle frame pulse marks the start of a 32-slot frame. The clock runs at twice the bit rate, and each slot carries 8 bits, most significant bit first. In strobed mode a strobe held high for eight clock cycles frames a single byte, with one bit per clock.

In framed mode, slot 0 carries a signalling side channel and slot 1 carries a control side channel. Both are driven from and captured into plain register ports, and each has its own enable. The signalling channel can run at the full 8 bits or at a narrow 2 bits. Slot 2 carries the voice byte. In strobed mode only the voice byte is carried. The voice byte reaches the block on a valid/ready stream and leaves it on a valid/ready stream. The transmit side accepts one byte into a holding register. A byte offered while the register is full, or while the voice slot is on the wire, waits. The receive side cannot stall the link. An undelivered byte stays stable until it is taken or until the next frame's byte replaces it.

A delayed copy of the frame pulse or strobe is produced so that a second port can take the following slots of the same link.

Top module: `tdm_voice_port`

## Requirements
- R1: In framed mode, the clock cycle after `sync_in` is sampled high is the first cycle of slot 0. Each slot lasts 16 cycles and each bit lasts 2 cycles, with bit 7 first. A driven bit is held for both cycles of its bit period, and the input is sampled at the clock edge that ends the first cycle.
- R2: In framed mode, `sync_out` is high for exactly one cycle, 64 cycles (4 slots) after the cycle in which `sync_in` was high.
- R3: In slot 0, when `d_en` is 1, the block drives `d_tx` on the line. With `d_wide` = 1 it drives all 8 bits. With `d_wide` = 0 it drives only bit positions 7 and 6, and `ser_oe` is low for the other 6 positions.
- R4: Slot 0 input bits are written into `d_rx` at matching bit positions in every frame, whether `d_en` is 1 or 0. With `d_wide` = 0 only `d_rx[7:6]` change.
- R5: `d_tx` is sent again in every frame. It is never consumed.
- R6: In slot 1, `c_tx` is driven when `c_en` is 1. The input byte is written to `c_rx` only when `c_en` is 1, and otherwise `c_rx` is unchanged.
- R7: The voice slot (slot 2, or the strobe window) always drives the line. It sends the held byte, or 8'hFF if no byte is held. The held byte is freed at the end of the slot. `tx_ready` is low while a byte is held or while the voice slot is in progress.
- R8: After the voice slot's last bit is sampled, `rx_valid` rises with the received byte on `rx_data`. Both stay stable until `rx_ready` is seen high, or until a newer byte overwrites them.
- R9: `ser_oe` is low in slots 3 to 31, and it is low in framed mode before the first frame pulse.
- R10: In strobed mode, while `sync_in` is high, the eight cycles carry the voice byte bit 7 first at one bit per cycle, and input is sampled on each edge. No side-channel slot exists in this mode.
- R11: In strobed mode, `sync_out` is high for the 8 cycles that follow the last strobe cycle.
- R12: Reset clears `d_rx`, `c_rx`, `rx_valid`, the held byte and all sync state, so `ser_oe` and `sync_out` are low and `tx_ready` is high.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | Link clock (twice the bit rate in framed mode, the bit rate in strobed mode) |
| rst_n | input | 1 | Asynchronous reset, active low |
| mode_tdm | input | 1 | 1 selects framed TDM mode, 0 selects strobed mode |
| sync_in | input | 1 | Frame pulse (framed) or byte strobe (strobed) |
| sync_out | output | 1 | Delayed frame pulse or strobe for a chained port |
| ser_in | input | 1 | Serial receive data |
| ser_out | output | 1 | Serial transmit data |
| ser_oe | output | 1 | Drive enable for `ser_out`; low means the pad floats |
| d_en | input | 1 | Signalling channel transmit enable |
| d_wide | input | 1 | 1 selects an 8-bit signalling channel, 0 selects 2 bits |
| d_tx | input | 8 | Signalling byte to send each frame |
| d_rx | output | 8 | Last captured signalling bits |
| c_en | input | 1 | Control channel enable |
| c_tx | input | 8 | Control byte to send each frame |
| c_rx | output | 8 | Last captured control byte |
| tx_valid | input | 1 | Voice byte offered by the codec |
| tx_ready | output | 1 | Block can accept a voice byte |
| tx_data | input | 8 | Voice byte from the codec |
| rx_valid | output | 1 | Received voice byte available |
| rx_ready | input | 1 | Codec takes the received byte |
| rx_data | output | 8 | Received voice byte |

## Verification
A table of framed-mode frames varies both side-channel enables, the signalling width, and whether a voice byte is held. The bench checks the drive-enable pattern and the data of each of the first three slots, so it can tell a wrong slot, a wrong bit order or a wrong width from a missing gate on the enables. The input bytes differ in each frame, and the disabled-channel frames show whether the signalling channel keeps capturing while the control channel holds its value. Two frames with `rx_ready` low separate holding a byte from overwriting it. A strobed byte checks the bit order at one bit per clock and the eight cycles of the delayed strobe.

// File: rtl/tdmp_pkg.sv
package tdmp_pkg;
  localparam int BYTE_W = 8;
  localparam int BIT_IDX_W = 3;
  typedef logic [BYTE_W-1:0] byte_t;
endpackage

// File: rtl/tdmp_timing.sv
module tdmp_timing #(
  parameter int SLOTS         = 32,
  parameter int TICKS_PER_BIT = 2,
  parameter int DELAY_SLOTS   = 4,
  parameter int STROBE_SLOT   = 2,
  parameter int SLOT_W        = $clog2(SLOTS)
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic              mode_tdm,
  input  logic              sync_in,
  output logic              active,
  output logic [SLOT_W-1:0] slot,
  output logic [2:0]        bitn,
  output logic              sample,
  output logic              slot_end,
  output logic              sync_out
);
  import tdmp_pkg::*;

  localparam int PH_W  = $clog2(TICKS_PER_BIT);
  localparam int CNT_W = PH_W + BIT_IDX_W + SLOT_W;
  localparam logic [CNT_W-1:0] CNT_LAST  = CNT_W'(SLOTS * BYTE_W * TICKS_PER_BIT - 1);
  localparam logic [CNT_W-1:0] CNT_DELAY = CNT_W'(DELAY_SLOTS * BYTE_W * TICKS_PER_BIT - 1);
  localparam logic [PH_W-1:0]  PH_SAMPLE = PH_W'(TICKS_PER_BIT / 2 - 1);
  localparam logic [PH_W-1:0]  PH_LAST   = PH_W'(TICKS_PER_BIT - 1);
  localparam logic [SLOT_W-1:0] STB_SLOT = SLOT_W'(STROBE_SLOT);

  logic [CNT_W-1:0] cnt_q;
  logic             locked_q;
  logic [2:0]       sbit_q;
  logic [3:0]       trail_q;

  logic [PH_W-1:0]  phase;
  assign phase = cnt_q[PH_W-1:0];

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      cnt_q    <= '0;
      locked_q <= 1'b0;
      sbit_q   <= '0;
      trail_q  <= '0;
    end else if (mode_tdm) begin
      sbit_q  <= '0;
      trail_q <= '0;
      if (sync_in) begin
        cnt_q    <= '0;
        locked_q <= 1'b1;
      end else if (cnt_q == CNT_LAST) begin
        cnt_q <= '0;
      end else begin
        cnt_q <= cnt_q + 1'b1;
      end
    end else begin
      locked_q <= 1'b0;
      cnt_q    <= '0;
      if (sync_in) sbit_q <= sbit_q + 3'd1;
      else         sbit_q <= '0;
      if (sync_in && sbit_q == 3'd7) trail_q <= 4'd8;
      else if (trail_q != 4'd0)      trail_q <= trail_q - 4'd1;
    end
  end

  always_comb begin
    if (mode_tdm) begin
      active   = locked_q;
      slot     = cnt_q[PH_W+BIT_IDX_W +: SLOT_W];
      bitn     = cnt_q[PH_W +: BIT_IDX_W];
      sample   = locked_q && (phase == PH_SAMPLE);
      slot_end = locked_q && (bitn == 3'd7) && (phase == PH_LAST);
      sync_out = locked_q && (cnt_q == CNT_DELAY);
    end else begin
      active   = sync_in;
      slot     = STB_SLOT;
      bitn     = sbit_q;
      sample   = sync_in;
      slot_end = sync_in && (sbit_q == 3'd7);
      sync_out = (trail_q != 4'd0);
    end
  end

  AST_SYNC_ONE_CYCLE: assert property (@(posedge clk) disable iff (!rst_n)
    (mode_tdm && sync_out) |=> !(mode_tdm && sync_out)); // R2

  AST_TRAIL_BOUND: assert property (@(posedge clk) disable iff (!rst_n)
    (!mode_tdm && sync_out && !$past(sync_in)) |-> (trail_q <= 4'd8)); // R11
endmodule

// File: rtl/tdmp_side_chan.sv
module tdmp_side_chan #(
  parameter int SLOT          = 0,
  parameter int NARROW        = 2,
  parameter bit CAP_WHEN_OFF  = 1'b1,
  parameter int SLOT_W        = 5
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic              active,
  input  logic [SLOT_W-1:0] slot,
  input  logic [2:0]        bitn,
  input  logic              sample,
  input  logic              en,
  input  logic              wide,
  input  tdmp_pkg::byte_t   tx_byte,
  input  logic              bit_in,
  output logic              drv_oe,
  output logic              drv_bit,
  output tdmp_pkg::byte_t   rx_byte
);
  localparam logic [SLOT_W-1:0] MY_SLOT  = SLOT_W'(SLOT);
  localparam logic [3:0]        NARROW_L = 4'(NARROW);

  logic       in_slot;
  logic       in_width;
  logic [2:0] pos;

  assign in_slot  = active && (slot == MY_SLOT);
  assign in_width = wide || ({1'b0, bitn} < NARROW_L);
  assign pos      = 3'd7 - bitn;
  assign drv_oe   = in_slot && en && in_width;
  assign drv_bit  = tx_byte[pos];

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) rx_byte <= '0;
    else if (sample && in_slot && in_width && (en || CAP_WHEN_OFF)) rx_byte[pos] <= bit_in;
  end
endmodule

// File: rtl/tdmp_pcm_buf.sv
module tdmp_pcm_buf (
  input  logic            clk,
  input  logic            rst_n,
  input  logic            tx_valid,
  input  tdmp_pkg::byte_t tx_data,
  output logic            tx_ready,
  input  logic            busy,
  input  logic            consume,
  output logic            hold_full,
  output tdmp_pkg::byte_t hold_byte,
  input  logic            rx_sample,
  input  logic [2:0]      rx_pos,
  input  logic            rx_bit,
  output logic            rx_valid,
  input  logic            rx_ready,
  output tdmp_pkg::byte_t rx_data
);
  tdmp_pkg::byte_t sh_q;
  logic            deliver;
  logic [2:0]      idx;

  assign tx_ready = !hold_full && !busy;
  assign idx      = 3'd7 - rx_pos;
  assign deliver  = rx_sample && (rx_pos == 3'd7);

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      hold_full <= 1'b0;
      hold_byte <= '0;
    end else if (tx_valid && tx_ready) begin
      hold_full <= 1'b1;
      hold_byte <= tx_data;
    end else if (consume) begin
      hold_full <= 1'b0;
    end
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      sh_q     <= '0;
      rx_valid <= 1'b0;
      rx_data  <= '0;
    end else begin
      if (rx_sample) sh_q[idx] <= rx_bit;
      if (deliver) begin
        rx_data  <= {sh_q[7:1], rx_bit};
        rx_valid <= 1'b1;
      end else if (rx_valid && rx_ready) begin
        rx_valid <= 1'b0;
      end
    end
  end

  AST_HOLD_KEEP: assert property (@(posedge clk) disable iff (!rst_n)
    (hold_full && !consume) |=> (hold_full && $stable(hold_byte))); // R7

  AST_RX_KEEP: assert property (@(posedge clk) disable iff (!rst_n)
    (rx_valid && !rx_ready && !deliver) |=> (rx_valid && $stable(rx_data))); // R8
endmodule

// File: rtl/tdm_voice_port.sv
module tdm_voice_port #(
  parameter int SLOTS         = 32,
  parameter int TICKS_PER_BIT = 2,
  parameter int DELAY_SLOTS   = 4,
  parameter int D_SLOT        = 0,
  parameter int C_SLOT        = 1,
  parameter int PCM_SLOT      = 2,
  parameter int D_NARROW      = 2
) (
  input  logic       clk,
  input  logic       rst_n,
  input  logic       mode_tdm,
  input  logic       sync_in,
  output logic       sync_out,
  input  logic       ser_in,
  output logic       ser_out,
  output logic       ser_oe,
  input  logic       d_en,
  input  logic       d_wide,
  input  logic [7:0] d_tx,
  output logic [7:0] d_rx,
  input  logic       c_en,
  input  logic [7:0] c_tx,
  output logic [7:0] c_rx,
  input  logic       tx_valid,
  output logic       tx_ready,
  input  logic [7:0] tx_data,
  output logic       rx_valid,
  input  logic       rx_ready,
  output logic [7:0] rx_data
);
  localparam int SLOT_W = $clog2(SLOTS);
  localparam logic [SLOT_W-1:0] PCM_S = SLOT_W'(PCM_SLOT);

  logic              tm_active, tm_sample, tm_end;
  logic [SLOT_W-1:0] tm_slot;
  logic [2:0]        tm_bit;

  tdmp_timing #(
    .SLOTS(SLOTS), .TICKS_PER_BIT(TICKS_PER_BIT), .DELAY_SLOTS(DELAY_SLOTS),
    .STROBE_SLOT(PCM_SLOT), .SLOT_W(SLOT_W)
  ) u_tim (
    .clk(clk), .rst_n(rst_n), .mode_tdm(mode_tdm), .sync_in(sync_in),
    .active(tm_active), .slot(tm_slot), .bitn(tm_bit), .sample(tm_sample),
    .slot_end(tm_end), .sync_out(sync_out)
  );

  logic d_oe, d_bit, c_oe, c_bit;

  tdmp_side_chan #(.SLOT(D_SLOT), .NARROW(D_NARROW), .CAP_WHEN_OFF(1'b1), .SLOT_W(SLOT_W)) u_dch (
    .clk(clk), .rst_n(rst_n), .active(tm_active), .slot(tm_slot), .bitn(tm_bit),
    .sample(tm_sample), .en(d_en), .wide(d_wide), .tx_byte(d_tx), .bit_in(ser_in),
    .drv_oe(d_oe), .drv_bit(d_bit), .rx_byte(d_rx)
  );

  tdmp_side_chan #(.SLOT(C_SLOT), .NARROW(8), .CAP_WHEN_OFF(1'b0), .SLOT_W(SLOT_W)) u_cch (
    .clk(clk), .rst_n(rst_n), .active(tm_active), .slot(tm_slot), .bitn(tm_bit),
    .sample(tm_sample), .en(c_en), .wide(1'b1), .tx_byte(c_tx), .bit_in(ser_in),
    .drv_oe(c_oe), .drv_bit(c_bit), .rx_byte(c_rx)
  );

  logic            pcm_oe, hold_full;
  tdmp_pkg::byte_t hold_byte;
  logic [2:0]      tpos;

  assign pcm_oe = tm_active && (tm_slot == PCM_S);
  assign tpos   = 3'd7 - tm_bit;

  tdmp_pcm_buf u_pcm (
    .clk(clk), .rst_n(rst_n), .tx_valid(tx_valid), .tx_data(tx_data), .tx_ready(tx_ready),
    .busy(pcm_oe), .consume(pcm_oe && tm_end), .hold_full(hold_full), .hold_byte(hold_byte),
    .rx_sample(pcm_oe && tm_sample), .rx_pos(tm_bit), .rx_bit(ser_in),
    .rx_valid(rx_valid), .rx_ready(rx_ready), .rx_data(rx_data)
  );

  always_comb begin
    ser_oe  = d_oe || c_oe || pcm_oe;
    ser_out = 1'b0;
    if (d_oe)        ser_out = d_bit;
    else if (c_oe)   ser_out = c_bit;
    else if (pcm_oe) ser_out = hold_full ? hold_byte[tpos] : 1'b1;
  end

  AST_OE_WINDOW: assert property (@(posedge clk) disable iff (!rst_n)
    ser_oe |-> (tm_active && (tm_slot <= PCM_S))); // R9

  AST_C_FROZEN_OFF: assert property (@(posedge clk) disable iff (!rst_n)
    !c_en |=> $stable(c_rx)); // R6
endmodule

// File: tb/tdm_voice_port_test.sv
module tdm_voice_port_test;
  localparam int CLK_NS = 10;

  typedef struct packed {
    logic den, cen, dwide, give;
    logic [7:0] dtx, ctx, ptx, dind, dinc, dinp;
  } vec_t;

  localparam vec_t VECS [0:7] = '{
    '{1'b1, 1'b1, 1'b1, 1'b1, 8'hA5, 8'h3C, 8'h96, 8'h5A, 8'hC3, 8'h69},
    '{1'b1, 1'b1, 1'b0, 1'b1, 8'h7E, 8'h81, 8'h01, 8'h12, 8'h0F, 8'hF0},
    '{1'b0, 1'b0, 1'b0, 1'b0, 8'hFF, 8'hFF, 8'h00, 8'h80, 8'hAA, 8'h00},
    '{1'b0, 1'b1, 1'b1, 1'b1, 8'h00, 8'hE7, 8'h80, 8'h3B, 8'h55, 8'hFF},
    '{1'b1, 1'b0, 1'b1, 1'b0, 8'h42, 8'h99, 8'h00, 8'hC4, 8'h11, 8'h01},
    '{1'b1, 1'b0, 1'b1, 1'b1, 8'h42, 8'h99, 8'h7F, 8'h21, 8'h66, 8'h80},
    '{1'b1, 1'b1, 1'b0, 1'b1, 8'h40, 8'h00, 8'h55, 8'hFF, 8'h00, 8'hAA},
    '{1'b0, 1'b1, 1'b1, 1'b0, 8'h18, 8'hD2, 8'h00, 8'h0C, 8'h9E, 8'h3E}
  };

  logic clk = 1'b0, rst_n = 1'b0, mode_tdm = 1'b1, sync_in = 1'b0, ser_in = 1'b0;
  logic d_en = 1'b0, d_wide = 1'b0, c_en = 1'b0, tx_valid = 1'b0, rx_ready = 1'b1;
  logic [7:0] d_tx = '0, c_tx = '0, tx_data = '0;
  logic sync_out, ser_out, ser_oe, tx_ready, rx_valid;
  logic [7:0] d_rx, c_rx, rx_data;

  int checks = 0, errors = 0;
  bit done = 1'b0;
  logic [7:0] exp_d = '0, exp_c = '0;

  always #(CLK_NS / 2) clk = ~clk;

  tdm_voice_port uut (
    .clk(clk), .rst_n(rst_n), .mode_tdm(mode_tdm), .sync_in(sync_in), .sync_out(sync_out),
    .ser_in(ser_in), .ser_out(ser_out), .ser_oe(ser_oe), .d_en(d_en), .d_wide(d_wide),
    .d_tx(d_tx), .d_rx(d_rx), .c_en(c_en), .c_tx(c_tx), .c_rx(c_rx),
    .tx_valid(tx_valid), .tx_ready(tx_ready), .tx_data(tx_data),
    .rx_valid(rx_valid), .rx_ready(rx_ready), .rx_data(rx_data)
  );

  task automatic check(input string tag, input logic [31:0] act, input logic [31:0] exp);
    checks++;
    if (act !== exp) begin
      errors++;
      $display("FAIL %s actual=%h expected=%h", tag, act, exp);
    end
  endtask

  task automatic run_frame(input vec_t v);
    logic [7:0] obs_oe [3];
    logic [7:0] obs_dat [3];
    logic [7:0] dmask;
    int phase_bad = 0, extra = 0, fp_cnt = 0, fp_at = -1;
    d_en = v.den; c_en = v.cen; d_wide = v.dwide; d_tx = v.dtx; c_tx = v.ctx;
    for (int i = 0; i < 3; i++) begin obs_oe[i] = '0; obs_dat[i] = '0; end
    for (int k = 0; k < 512; k++) begin
      int slot, bt;
      @(negedge clk);
      slot = k / 16; bt = (k / 2) % 8;
      sync_in  = (k == 511);
      tx_valid = v.give && (k == 0);
      tx_data  = v.ptx;
      case (slot)
        0: ser_in = v.dind[7-bt];
        1: ser_in = v.dinc[7-bt];
        2: ser_in = v.dinp[7-bt];
        default: ser_in = k[2];
      endcase
      #1;
      if (slot < 3) begin
        if (k % 2 == 0) begin
          obs_oe[slot][7-bt]  = ser_oe;
          obs_dat[slot][7-bt] = ser_out;
        end else if (ser_oe !== obs_oe[slot][7-bt] || (ser_oe && ser_out !== obs_dat[slot][7-bt])) begin
          phase_bad++;
        end
      end else if (ser_oe) extra++;
      if (sync_out) begin fp_cnt++; fp_at = k; end
      if (k == 0) check("R7 tx_ready idle", 32'(tx_ready), 32'd1);
      if (k == 1 && v.give) check("R7 tx_ready held", 32'(tx_ready), 32'd0);
      if (k == 47) begin
        check("R8 rx_valid", 32'(rx_valid), 32'd1);
        check("R8 rx_data", 32'(rx_data), 32'(v.dinp));
      end
      if (k == 48) check("R8 rx_valid after", 32'(rx_valid), 32'(!rx_ready));
      if (k == 511 && !rx_ready) check("R8 rx held", {23'd0, rx_valid, rx_data}, {23'd0, 1'b1, v.dinp});
    end
    dmask = v.den ? (v.dwide ? 8'hFF : 8'hC0) : 8'h00;
    exp_d = v.dwide ? v.dind : {v.dind[7:6], exp_d[5:0]};
    if (v.cen) exp_c = v.dinc;
    check("R1 bit held both phases", 32'(phase_bad), 32'd0);
    check("R3 d oe mask", 32'(obs_oe[0]), 32'(dmask));
    check("R3 R5 d data", 32'(obs_dat[0] & dmask), 32'(v.dtx & dmask));
    check("R6 c oe", 32'(obs_oe[1]), v.cen ? 32'hFF : 32'h0);
    check("R6 c data", 32'(obs_dat[1] & obs_oe[1]), 32'(v.cen ? v.ctx : 8'h00));
    check("R7 pcm oe", 32'(obs_oe[2]), 32'hFF);
    check("R7 pcm data", 32'(obs_dat[2]), 32'(v.give ? v.ptx : 8'hFF));
    check("R9 oe outside slots", 32'(extra), 32'd0);
    check("R2 sync_out count", 32'(fp_cnt), 32'd1);
    check("R2 sync_out position", 32'(fp_at), 32'd63);
    check("R4 d_rx", 32'(d_rx), 32'(exp_d));
    check("R6 c_rx", 32'(c_rx), 32'(exp_c));
  endtask

  initial begin
    #(CLK_NS * 200000);
    if (!done) begin
      errors++;
      $display("FAIL watchdog actual=timeout expected=finish");
      $display("CHECKS %0d ERRORS %0d", checks, errors);
      $finish;
    end
  end

  initial begin
    logic [7:0] s_oe, s_dat;
    logic [9:0] s_trail;
    int pre_oe;
    repeat (3) @(negedge clk);
    #1;
    check("R12 reset outs", {26'd0, ser_oe, sync_out, rx_valid, tx_ready}, 32'h1);
    check("R12 reset regs", {16'd0, d_rx, c_rx}, 32'd0);
    @(negedge clk);
    rst_n = 1'b1;
    pre_oe = 0;
    for (int i = 0; i < 20; i++) begin
      @(negedge clk); #1;
      if (ser_oe || sync_out) pre_oe++;
    end
    check("R9 no drive before sync", 32'(pre_oe), 32'd0);

    @(negedge clk);
    sync_in = 1'b1;
    foreach (VECS[i]) run_frame(VECS[i]);

    rx_ready = 1'b0;
    run_frame(VECS[0]);
    run_frame(VECS[1]);

    mode_tdm = 1'b0; sync_in = 1'b0; rx_ready = 1'b1;
    tx_valid = 1'b1; tx_data = 8'hB4;
    #1;
    check("R7 tx_ready strobe", 32'(tx_ready), 32'd1);
    @(negedge clk);
    tx_valid = 1'b0;
    #1;
    check("R7 tx_ready full", 32'(tx_ready), 32'd0);
    for (int j = 0; j < 8; j++) begin
      @(negedge clk);
      sync_in = 1'b1;
      ser_in  = 8'h3D >> (7 - j);
      #1;
      s_oe[7-j]  = ser_oe;
      s_dat[7-j] = ser_out;
    end
    for (int j = 0; j < 10; j++) begin
      @(negedge clk);
      sync_in = 1'b0;
      #1;
      s_trail[j] = sync_out;
      if (j == 0) begin
        check("R10 strobe rx", {23'd0, rx_valid, rx_data}, {23'd0, 1'b1, 8'h3D});
        check("R10 oe after strobe", 32'(ser_oe), 32'd0);
      end
    end
    check("R10 strobe oe", 32'(s_oe), 32'hFF);
    check("R10 strobe data", 32'(s_dat), 32'hB4);
    check("R11 delayed strobe", 32'(s_trail), 32'h0FF);

    done = 1'b1;
    $display("CHECKS %0d ERRORS %0d", checks, errors);
    $finish;
  end
endmodule